// File: doc/BRIEF.md
# Open-Row DRAM Bank Sequencer

This block is a behavioural model of one DRAM bank together with the sequencer that runs accesses into it. The bank stores `ROWS` rows of `COLS` words, each word `WORD_W` bits wide. The defaults are a 1024-bit row made of 64 words of 16 bits. All accesses go through a single row buffer. A request whose row is already in the buffer runs at once. For any other request, the sequencer first restores the old row to the array if that row was modified, then spends a fixed number of cycles fetching the new row, and only then serves the request.

Requests use a valid/ready handshake. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. The requester must keep `req_valid` and its payload steady until that edge. `req_ready` is a function of internal state only. It drops during restore, fetch, the cycle that replays a request after a fetch, and every cycle of a multi-word read except the last. A read names a start column and a length. The block then returns consecutive words on `rsp_valid`/`rsp_data`, one per cycle with no gaps, and raises `rsp_last` with the final word. The response side has no back-pressure: the consumer must take a word in any cycle where `rsp_valid` is high. Writes return nothing.

Top module: `dram_open_row_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `rsp_last` are 0, no row is open, and every stored word reads as zero.
- R2: A request to the open row is a hit. A hit read returns its first word in the cycle after acceptance. A hit single read or a hit write leaves `req_ready` high.
- R3: A request to a row that is not open, while the open row is unmodified or no row is open, returns its first read word `FETCH_LAT`+1 cycles after acceptance. For a write, `req_ready` comes back after the same number of cycles.
- R4: A miss while the open row holds a write first restores that row for `WB_LAT` cycles, which adds `WB_LAT` cycles to the delay of R3.
- R5: A write (`req_write`=1) changes only the addressed word. Later reads see it, including after the row has been restored and fetched again.
- R6: A read returns its words from ascending columns on consecutive cycles with no gap, with `rsp_last` high on the final word only.
- R7: The number of words is `req_len`, clipped so that the read ends at the last column of the row. A `req_len` of 0 reads one word.
- R8: Responses come out in acceptance order. `req_ready` is low while a multi-word read still has words to send after the current one.
- R9: The column index is the low log2(`COLS`) address bits (6 by default). The row index is the address bits above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write one word, 0 = read |
| req_addr | input | log2(ROWS)+log2(COLS) | Row in upper bits, column in lower bits |
| req_wdata | input | WORD_W | Write data |
| req_len | input | log2(COLS)+1 | Read length in words (0 means 1) |
| rsp_valid | output | 1 | Read word present |
| rsp_data | output | WORD_W | Read word |
| rsp_last | output | 1 | Final word of the current read |

## Verification
A wrong open-row tag or a wrong dirty flag does not corrupt data right away. It shows up as a wrong handshake timing: `req_ready` falls or rises at the wrong edge, or the first word comes out in the wrong cycle, within `WB_LAT`+`FETCH_LAT`+1 cycles of the next request. A restore that was skipped shows later, as stale data on the first read after that row is fetched again. A wrong column pointer or a wrong length clip shows on the data or `rsp_last` of the same read. For these reasons the bench compares `req_ready`, `rsp_valid`, `rsp_data` and `rsp_last` on every cycle.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB,
    ST_FETCH,
    ST_EXEC,
    ST_STREAM
  } seq_state_e;
endpackage

// File: rtl/dseq_bank_array.sv
// Storage array: one whole row is read or restored at a time.
module dseq_bank_array #(
  parameter int WORD_W = 16,
  parameter int COLS   = 64,
  parameter int ROWS   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wb_en,
  input  logic [$clog2(ROWS)-1:0]       wb_row,
  input  logic [WORD_W*COLS-1:0]        wb_row_data,
  input  logic [$clog2(ROWS)-1:0]       rd_row,
  output logic [WORD_W*COLS-1:0]        rd_row_data
);
  localparam int ROW_W = WORD_W * COLS;

  logic [ROW_W-1:0] rows_q [ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) rows_q[r] <= '0;
    end else if (wb_en) begin
      rows_q[wb_row] <= wb_row_data;
    end
  end

  assign rd_row_data = rows_q[rd_row];
endmodule

// File: rtl/dseq_row_buffer.sv
// Open-row buffer: bulk load from the array, single-word write, single-word read.
module dseq_row_buffer #(
  parameter int WORD_W = 16,
  parameter int COLS   = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_en,
  input  logic [WORD_W*COLS-1:0]     load_data,
  input  logic                       wr_en,
  input  logic [$clog2(COLS)-1:0]    wr_col,
  input  logic [WORD_W-1:0]          wr_data,
  input  logic [$clog2(COLS)-1:0]    rd_col,
  output logic [WORD_W-1:0]          rd_word,
  output logic [WORD_W*COLS-1:0]     row_data
);
  localparam int ROW_W = WORD_W * COLS;

  logic [ROW_W-1:0] line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
    end else if (load_en) begin
      line_q <= load_data;
    end else if (wr_en) begin
      line_q[WORD_W*int'(wr_col) +: WORD_W] <= wr_data;
    end
  end

  assign rd_word  = line_q[WORD_W*int'(rd_col) +: WORD_W];
  assign row_data = line_q;
endmodule

// File: rtl/dseq_ctrl.sv
// Sequencer: hit detection, restore/fetch timing, replay, read streaming.
module dseq_ctrl
  import dseq_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int COLS      = 64,
  parameter int ROWS      = 8,
  parameter int FETCH_LAT = 8,
  parameter int WB_LAT    = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  output logic                                  req_ready,
  input  logic                                  req_write,
  input  logic [$clog2(ROWS)+$clog2(COLS)-1:0]  req_addr,
  input  logic [WORD_W-1:0]                     req_wdata,
  input  logic [$clog2(COLS):0]                 req_len,
  output logic                                  rsp_valid,
  output logic [WORD_W-1:0]                     rsp_data,
  output logic                                  rsp_last,
  output logic                                  row_hit,
  output logic                                  buf_load,
  output logic                                  buf_wr,
  output logic [$clog2(COLS)-1:0]               buf_wr_col,
  output logic [WORD_W-1:0]                     buf_wr_data,
  output logic [$clog2(COLS)-1:0]               buf_rd_col,
  input  logic [WORD_W-1:0]                     buf_rd_word,
  output logic                                  arr_wb,
  output logic [$clog2(ROWS)-1:0]               arr_wb_row,
  output logic [$clog2(ROWS)-1:0]               arr_rd_row
);
  localparam int CA_W    = $clog2(COLS);
  localparam int RA_W    = $clog2(ROWS);
  localparam int AW      = RA_W + CA_W;
  localparam int LEN_W   = CA_W + 1;
  localparam int MAX_LAT = (FETCH_LAT > WB_LAT) ? FETCH_LAT : WB_LAT;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [RA_W-1:0]   open_row_q;
  logic              row_valid_q, dirty_q;
  logic              pend_write_q;
  logic [RA_W-1:0]   pend_row_q;
  logic [CA_W-1:0]   pend_col_q;
  logic [WORD_W-1:0] pend_wdata_q;
  logic [LEN_W-1:0]  pend_len_q;
  logic [CA_W-1:0]   scol_q;
  logic [LEN_W-1:0]  sleft_q;

  logic [RA_W-1:0]   in_row;
  logic [CA_W-1:0]   in_col;
  logic              accept, ex_fire, ex_write;
  logic [CA_W-1:0]   ex_col;
  logic [WORD_W-1:0] ex_wdata;
  logic [LEN_W-1:0]  ex_len, ex_beats;

  function automatic logic [LEN_W-1:0] beat_count(input logic [CA_W-1:0] col,
                                                  input logic [LEN_W-1:0] len);
    logic [LEN_W-1:0] room;
    room = LEN_W'(COLS) - LEN_W'(col);
    if (len == '0)      return LEN_W'(1);
    else if (len < room) return len;
    else                return room;
  endfunction

  assign in_row    = req_addr[AW-1:CA_W];
  assign in_col    = req_addr[CA_W-1:0];
  assign req_ready = (state_q == ST_IDLE);
  assign row_hit   = row_valid_q && (in_row == open_row_q);
  assign accept    = req_valid && req_ready;
  assign ex_fire   = (accept && row_hit) || (state_q == ST_EXEC);

  always_comb begin
    if (state_q == ST_EXEC) begin
      ex_write = pend_write_q;
      ex_col   = pend_col_q;
      ex_wdata = pend_wdata_q;
      ex_len   = pend_len_q;
    end else begin
      ex_write = req_write;
      ex_col   = in_col;
      ex_wdata = req_wdata;
      ex_len   = req_len;
    end
  end

  assign ex_beats    = beat_count(ex_col, ex_len);
  assign buf_rd_col  = (state_q == ST_STREAM) ? scol_q : ex_col;
  assign buf_wr      = ex_fire && ex_write;
  assign buf_wr_col  = ex_col;
  assign buf_wr_data = ex_wdata;
  assign arr_wb      = (state_q == ST_WB) && (cnt_q == '0);
  assign arr_wb_row  = open_row_q;
  assign buf_load    = (state_q == ST_FETCH) && (cnt_q == '0);
  assign arr_rd_row  = pend_row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      open_row_q   <= '0;
      row_valid_q  <= 1'b0;
      dirty_q      <= 1'b0;
      pend_write_q <= 1'b0;
      pend_row_q   <= '0;
      pend_col_q   <= '0;
      pend_wdata_q <= '0;
      pend_len_q   <= '0;
      scol_q       <= '0;
      sleft_q      <= '0;
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      rsp_last     <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_last  <= 1'b0;
      if (ex_fire) begin
        state_q <= ST_IDLE;
        if (ex_write) begin
          dirty_q <= 1'b1;
        end else begin
          rsp_valid <= 1'b1;
          rsp_data  <= buf_rd_word;
          rsp_last  <= (ex_beats == LEN_W'(1));
          if (ex_beats > LEN_W'(1)) begin
            state_q <= ST_STREAM;
            scol_q  <= ex_col + 1'b1;
            sleft_q <= ex_beats - 1'b1;
          end
        end
      end else begin
        case (state_q)
          ST_IDLE: if (accept) begin
            pend_write_q <= req_write;
            pend_row_q   <= in_row;
            pend_col_q   <= in_col;
            pend_wdata_q <= req_wdata;
            pend_len_q   <= req_len;
            if (row_valid_q && dirty_q) begin
              state_q <= ST_WB;
              cnt_q   <= CNT_W'(WB_LAT - 1);
            end else begin
              state_q <= ST_FETCH;
              cnt_q   <= CNT_W'(FETCH_LAT - 1);
            end
          end
          ST_WB: begin
            if (cnt_q == '0) begin
              state_q <= ST_FETCH;
              cnt_q   <= CNT_W'(FETCH_LAT - 1);
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          ST_FETCH: begin
            if (cnt_q == '0) begin
              open_row_q  <= pend_row_q;
              row_valid_q <= 1'b1;
              dirty_q     <= 1'b0;
              state_q     <= ST_EXEC;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          ST_STREAM: begin
            rsp_valid <= 1'b1;
            rsp_data  <= buf_rd_word;
            rsp_last  <= (sleft_q == LEN_W'(1));
            scol_q    <= scol_q + 1'b1;
            sleft_q   <= sleft_q - 1'b1;
            if (sleft_q == LEN_W'(1)) state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dram_open_row_seq.sv
module dram_open_row_seq #(
  parameter int WORD_W    = 16,
  parameter int COLS      = 64,
  parameter int ROWS      = 8,
  parameter int FETCH_LAT = 8,
  parameter int WB_LAT    = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  output logic                                  req_ready,
  input  logic                                  req_write,
  input  logic [$clog2(ROWS)+$clog2(COLS)-1:0]  req_addr,
  input  logic [WORD_W-1:0]                     req_wdata,
  input  logic [$clog2(COLS):0]                 req_len,
  output logic                                  rsp_valid,
  output logic [WORD_W-1:0]                     rsp_data,
  output logic                                  rsp_last
);
  localparam int CA_W  = $clog2(COLS);
  localparam int RA_W  = $clog2(ROWS);
  localparam int ROW_W = WORD_W * COLS;

  logic              row_hit;
  logic              buf_load, buf_wr, arr_wb;
  logic [CA_W-1:0]   buf_wr_col, buf_rd_col;
  logic [WORD_W-1:0] buf_wr_data, buf_rd_word;
  logic [RA_W-1:0]   arr_wb_row, arr_rd_row;
  logic [ROW_W-1:0]  buf_row, arr_row;

  dseq_ctrl #(
    .WORD_W(WORD_W), .COLS(COLS), .ROWS(ROWS),
    .FETCH_LAT(FETCH_LAT), .WB_LAT(WB_LAT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_len(req_len),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
    .row_hit(row_hit),
    .buf_load(buf_load), .buf_wr(buf_wr), .buf_wr_col(buf_wr_col),
    .buf_wr_data(buf_wr_data), .buf_rd_col(buf_rd_col), .buf_rd_word(buf_rd_word),
    .arr_wb(arr_wb), .arr_wb_row(arr_wb_row), .arr_rd_row(arr_rd_row)
  );

  dseq_row_buffer #(.WORD_W(WORD_W), .COLS(COLS)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .load_en(buf_load), .load_data(arr_row),
    .wr_en(buf_wr), .wr_col(buf_wr_col), .wr_data(buf_wr_data),
    .rd_col(buf_rd_col), .rd_word(buf_rd_word), .row_data(buf_row)
  );

  dseq_bank_array #(.WORD_W(WORD_W), .COLS(COLS), .ROWS(ROWS)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .wb_en(arr_wb), .wb_row(arr_wb_row), .wb_row_data(buf_row),
    .rd_row(arr_rd_row), .rd_row_data(arr_row)
  );
endmodule

// File: rtl/dseq_checker.sv
module dseq_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic req_write,
  input logic row_hit,
  input logic rsp_valid,
  input logic rsp_last
);
  AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n) rsp_last |-> rsp_valid); // R6
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_last) |=> rsp_valid); // R6
  AST_BUSY_IN_STREAM: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_last) |-> !req_ready); // R8
  AST_HIT_READ_NEXT: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready && !req_write && row_hit) |=> rsp_valid); // R2
  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready && !row_hit) |=> !req_ready); // R3
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready && req_write) |=> !rsp_valid); // R5
endmodule

bind dram_open_row_seq dseq_checker u_chk (.*);

// File: tb/dram_open_row_seq_tb.sv
`timescale 1ns/1ps
module dram_open_row_seq_tb_top;
  localparam int WORD_W = 16, COLS = 64, ROWS = 8, FETCH_LAT = 8, WB_LAT = 4;
  localparam int AW = $clog2(ROWS) + $clog2(COLS);
  localparam int LW = $clog2(COLS) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [WORD_W-1:0] req_wdata = '0;
  logic [LW-1:0] req_len = '0;
  logic req_ready, rsp_valid, rsp_last;
  logic [WORD_W-1:0] rsp_data;

  always #2 clk = ~clk;

  dram_open_row_seq #(.WORD_W(WORD_W), .COLS(COLS), .ROWS(ROWS),
                      .FETCH_LAT(FETCH_LAT), .WB_LAT(WB_LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_len(req_len), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last));

  typedef struct { int cyc; int data; bit last; } beat_t;
  beat_t beats[$];
  int mem [ROWS*COLS];
  int m_open = 0; bit m_valid = 0, m_dirty = 0;
  int cyc = 0, busy_until = 0;
  int checks = 0, failures = 0;
  bit done = 0;
  string cur_req = "R1";

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_accept(int c, bit w, int addr, int data, int len);
    int row, col, d, n;
    row = addr / COLS; col = addr % COLS; d = 0;
    if (!(m_valid && row == m_open)) begin
      d = ((m_valid && m_dirty) ? WB_LAT : 0) + FETCH_LAT + 1;
      m_open = row; m_valid = 1; m_dirty = 0;
    end
    if (w) begin
      mem[addr] = data; m_dirty = 1; busy_until = c + d;
    end else begin
      n = (len == 0) ? 1 : ((len < COLS - col) ? len : COLS - col);
      for (int k = 0; k < n; k++) begin
        beat_t b;
        b.cyc = c + d + k; b.data = mem[row*COLS + col + k]; b.last = (k == n - 1);
        beats.push_back(b);
      end
      busy_until = c + d + n - 1;
    end
  endtask

  task automatic compare();
    bit ev; beat_t b;
    ev = (beats.size() > 0) && (beats[0].cyc == cyc);
    chk(req_ready == (cyc >= busy_until), "req_ready", int'(req_ready), int'(cyc >= busy_until));
    chk(rsp_valid == ev, "rsp_valid", int'(rsp_valid), int'(ev));
    if (ev) begin
      b = beats.pop_front();
      chk(int'(rsp_data) == b.data, "rsp_data", int'(rsp_data), b.data);
      chk(rsp_last == b.last, "rsp_last", int'(rsp_last), int'(b.last));
    end else begin
      chk(!rsp_last, "rsp_last idle", int'(rsp_last), 0);
    end
  endtask

  task automatic tick();
    @(posedge clk); cyc++;
    @(negedge clk); compare();
  endtask

  task automatic issue(bit w, int addr, int data, int len);
    bit acc;
    req_valid = 1; req_write = w; req_addr = AW'(addr);
    req_wdata = WORD_W'(data); req_len = LW'(len);
    do begin
      acc = req_ready;
      if (acc) model_accept(cyc + 1, w, addr, data, len);
      tick();
    end while (!acc);
    req_valid = 0;
  endtask

  task automatic drain();
    while (beats.size() > 0 || cyc < busy_until) tick();
    tick();
  endtask

  initial begin
    for (int i = 0; i < ROWS*COLS; i++) mem[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cur_req = "R1";
    chk(req_ready == 1'b1, "reset ready", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "reset rsp_valid", int'(rsp_valid), 0);
    chk(rsp_last == 1'b0, "reset rsp_last", int'(rsp_last), 0);
    rst_n = 1;
    tick();
    cur_req = "R3"; issue(0, 5, 0, 1); drain();
    cur_req = "R5"; issue(1, 5, 16'hA5A5, 0); issue(0, 5, 0, 1); issue(0, 6, 0, 1); drain();
    cur_req = "R2"; issue(0, 5, 0, 1); issue(0, 6, 0, 1); issue(1, 7, 16'h0BEE, 0); issue(0, 7, 0, 1); drain();
    cur_req = "R7"; issue(1, 63, 16'h1234, 0); issue(0, 60, 0, 8); drain();
    issue(0, 10, 0, 0); drain();
    cur_req = "R4"; issue(0, 3*COLS, 0, 1); drain();
    cur_req = "R5"; issue(0, 5, 0, 1); drain();
    cur_req = "R9"; issue(1, 2*COLS + 7, 16'h7777, 0); issue(1, 3*COLS + 7, 16'h3333, 0);
    issue(0, 2*COLS + 7, 0, 1); issue(0, 3*COLS + 7, 0, 1); issue(0, 7, 0, 1); drain();
    cur_req = "R6";
    for (int c = 0; c < COLS; c++) issue(1, 5*COLS + c, c*3 + 100, 0);
    issue(0, 5*COLS, 0, 64); drain();
    cur_req = "R7"; issue(0, 5*COLS + 1, 0, 100); issue(0, 5*COLS + 62, 0, 2); drain();
    cur_req = "R8";
    issue(0, 5*COLS + 20, 0, 3); issue(1, 5*COLS + 21, 16'hCAFE, 0); issue(0, 5*COLS + 21, 0, 1);
    issue(0, 2*COLS, 0, 4); issue(0, 3*COLS + 5, 0, 3); issue(1, 6*COLS + 1, 16'h0F0F, 0);
    issue(0, 6*COLS, 0, 3); issue(0, 5*COLS + 21, 0, 2); drain();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog run did not complete actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule